// File: doc/BRIEF.md
# Real-Mode Software Interrupt Entry Sequencer

This block carries out the fixed microsequence that enters a software interrupt handler in real mode. A start pulse captures an 8-bit vector together with the current flags, code selector, code base, code limit, return instruction pointer and stack pointer. The block then fetches two 16-bit words from the vector table and pushes three 16-bit words onto the stack. It finishes in one of two ways. If the new offset fits the code limit, it reports the new code state. If the offset does not fit, it reports a general-protection fault.

Memory traffic uses one read port and one write port. Each port has a valid/ready handshake, and the sequencer holds each step until its handshake completes. The result is given as a one-cycle pulse, either done or fault. The pulse carries the instruction pointer, code selector, code base, flags and stack pointer that the core must load.

Top module: `rm_int_seq`

## Requirements
- R1: After reset, busy_o, rd_valid_o, wr_valid_o, done_o and fault_o are all low.
- R2: The first read uses byte address vector×4 and returns the new instruction pointer. The second read uses vector×4+2 and returns the new selector. The vector is zero-extended, so vector FFh reads 3FCh and 3FEh.
- R3: Three writes follow the reads, in this order. The first writes flags bits 15:0 at sp−2. The second writes the old code selector at sp−4. The third writes the return instruction pointer at sp−6. All stack arithmetic wraps modulo 2^16.
- R4: While ready is low, a valid request holds its address and data stable, and the sequence does not advance.
- R5: On success, done_o pulses for one cycle, starting the cycle after the last write is accepted. ip_o carries the table offset, cs_sel_o the table selector, cs_base_o the selector shifted left by 4 (20 bits), and sp_o the value sp−6.
- R6: With done_o, flags_o equals the captured flags with bits 18, 16, 9 and 8 cleared; every other bit is kept.
- R7: When the table offset is greater than the code limit (unsigned compare), fault_o pulses in place of done_o. With the fault pulse, ip_o, cs_sel_o, cs_base_o and flags_o carry the captured inputs unchanged, and sp_o equals sp−6. An offset equal to the limit succeeds.
- R8: A start_i pulse while busy_o is high is ignored.
- R9: rd_valid_o and wr_valid_o are never high in the same cycle, and done_o and fault_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (accepted only when idle) |
| vector_i | input | 8 | Interrupt vector |
| flags_i | input | 32 | Current flags |
| cs_sel_i | input | 16 | Current code selector |
| cs_base_i | input | 20 | Current code base |
| cs_limit_i | input | 16 | Current code limit |
| next_ip_i | input | 16 | Return instruction pointer |
| sp_i | input | 16 | Current stack pointer |
| busy_o | output | 1 | Sequence in progress |
| rd_valid_o | output | 1 | Table read request |
| rd_addr_o | output | 20 | Table byte address |
| rd_ready_i | input | 1 | Read accepted; data valid this cycle |
| rd_data_i | input | 16 | Read data |
| wr_valid_o | output | 1 | Stack write request |
| wr_addr_o | output | 16 | Stack offset written |
| wr_data_o | output | 16 | Word pushed |
| wr_ready_i | input | 1 | Write accepted |
| done_o | output | 1 | Success pulse |
| fault_o | output | 1 | General-protection fault pulse |
| ip_o | output | 16 | Resulting instruction pointer |
| cs_sel_o | output | 16 | Resulting code selector |
| cs_base_o | output | 20 | Resulting code base |
| flags_o | output | 32 | Resulting flags |
| sp_o | output | 16 | Resulting stack pointer |

## Verification
Two pairs of events can fall in the same cycle. The first is a new start_i arriving while an earlier sequence is still stalled on a handshake. The bench drives this with ready patterns that stall every second or third cycle, and judges it by the bus trace: only the first sequence's five operations may appear, and they must come in order with their own values. The second is the outcome check when the table offset equals the code limit exactly, and when it is one above the limit. The bench judges that case by whether done_o or fault_o pulses in the single cycle after the last push, and by the field values carried with the pulse.

// File: rtl/rm_int_pkg.sv
package rm_int_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_IP, ST_RD_CS, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP, ST_FIN
  } step_e;

  // flag positions cleared on entry
  localparam int unsigned FL_TF = 8;
  localparam int unsigned FL_IF = 9;
  localparam int unsigned FL_RF = 16;
  localparam int unsigned FL_AC = 18;
endpackage

// File: rtl/rm_int_fsm.sv
module rm_int_fsm
  import rm_int_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  rd_ack_i,
  input  logic  wr_ack_i,
  output step_e step_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:    if (start_i)  step_d = ST_RD_IP;
      ST_RD_IP:   if (rd_ack_i) step_d = ST_RD_CS;
      ST_RD_CS:   if (rd_ack_i) step_d = ST_PUSH_FL;
      ST_PUSH_FL: if (wr_ack_i) step_d = ST_PUSH_CS;
      ST_PUSH_CS: if (wr_ack_i) step_d = ST_PUSH_IP;
      ST_PUSH_IP: if (wr_ack_i) step_d = ST_FIN;
      ST_FIN:                   step_d = ST_IDLE;
      default:                  step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  // R5
  fin_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_FIN |=> step_q == ST_IDLE);
endmodule

// File: rtl/rm_int_capture.sv
module rm_int_capture #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned FLAGS_W = 32,
  parameter int unsigned BASE_W  = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic [WORD_W-1:0]  sel_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic [WORD_W-1:0]  limit_i,
  input  logic [WORD_W-1:0]  ip_i,
  input  logic [WORD_W-1:0]  sp_i,
  input  logic               tbl_ip_we_i,
  input  logic               tbl_sel_we_i,
  input  logic [WORD_W-1:0]  rd_data_i,
  input  logic               push_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic [FLAGS_W-1:0] flags_o,
  output logic [WORD_W-1:0]  sel_o,
  output logic [BASE_W-1:0]  base_o,
  output logic [WORD_W-1:0]  limit_o,
  output logic [WORD_W-1:0]  ip_o,
  output logic [WORD_W-1:0]  sp_o,
  output logic [WORD_W-1:0]  tbl_ip_o,
  output logic [WORD_W-1:0]  tbl_sel_o
);
  localparam logic [WORD_W-1:0] PUSH_STEP = WORD_W'(WORD_W / 8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o     <= '0;
      flags_o   <= '0;
      sel_o     <= '0;
      base_o    <= '0;
      limit_o   <= '0;
      ip_o      <= '0;
      sp_o      <= '0;
      tbl_ip_o  <= '0;
      tbl_sel_o <= '0;
    end else begin
      if (load_i) begin
        vec_o   <= vec_i;
        flags_o <= flags_i;
        sel_o   <= sel_i;
        base_o  <= base_i;
        limit_o <= limit_i;
        ip_o    <= ip_i;
        sp_o    <= sp_i;
      end else if (push_i) begin
        sp_o <= sp_o - PUSH_STEP;  // wraps modulo 2^WORD_W
      end
      if (tbl_ip_we_i)  tbl_ip_o  <= rd_data_i;
      if (tbl_sel_we_i) tbl_sel_o <= rd_data_i;
    end
  end
endmodule

// File: rtl/rm_int_result.sv
module rm_int_result
  import rm_int_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned FLAGS_W = 32,
  parameter int unsigned BASE_W  = 20
) (
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic [WORD_W-1:0]  sel_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic [WORD_W-1:0]  limit_i,
  input  logic [WORD_W-1:0]  tbl_ip_i,
  input  logic [WORD_W-1:0]  tbl_sel_i,
  input  logic [WORD_W-1:0]  old_ip_i,
  output logic               over_limit_o,
  output logic [WORD_W-1:0]  ip_o,
  output logic [WORD_W-1:0]  sel_o,
  output logic [BASE_W-1:0]  base_o,
  output logic [FLAGS_W-1:0] flags_o
);
  localparam int unsigned SHIFT = BASE_W - WORD_W;
  localparam logic [FLAGS_W-1:0] CLR_MASK =
      (FLAGS_W'(1) << FL_TF) | (FLAGS_W'(1) << FL_IF) |
      (FLAGS_W'(1) << FL_RF) | (FLAGS_W'(1) << FL_AC);

  logic [BASE_W-1:0] new_base;
  assign new_base     = {tbl_sel_i, {SHIFT{1'b0}}};
  assign over_limit_o = tbl_ip_i > limit_i;

  always_comb begin
    if (over_limit_o) begin
      ip_o    = old_ip_i;
      sel_o   = sel_i;
      base_o  = base_i;
      flags_o = flags_i;
    end else begin
      ip_o    = tbl_ip_i;
      sel_o   = tbl_sel_i;
      base_o  = new_base;
      flags_o = flags_i & ~CLR_MASK;
    end
  end
endmodule

// File: rtl/rm_int_seq.sv
module rm_int_seq
  import rm_int_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned FLAGS_W = 32,
  parameter int unsigned ADDR_W  = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [VEC_W-1:0]   vector_i,
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic [WORD_W-1:0]  cs_sel_i,
  input  logic [ADDR_W-1:0]  cs_base_i,
  input  logic [WORD_W-1:0]  cs_limit_i,
  input  logic [WORD_W-1:0]  next_ip_i,
  input  logic [WORD_W-1:0]  sp_i,
  output logic               busy_o,
  output logic               rd_valid_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ready_i,
  input  logic [WORD_W-1:0]  rd_data_i,
  output logic               wr_valid_o,
  output logic [WORD_W-1:0]  wr_addr_o,
  output logic [WORD_W-1:0]  wr_data_o,
  input  logic               wr_ready_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [WORD_W-1:0]  ip_o,
  output logic [WORD_W-1:0]  cs_sel_o,
  output logic [ADDR_W-1:0]  cs_base_o,
  output logic [FLAGS_W-1:0] flags_o,
  output logic [WORD_W-1:0]  sp_o
);
  localparam int unsigned ENT_W = VEC_W + 2;
  localparam logic [WORD_W-1:0] WSTEP = WORD_W'(WORD_W / 8);

  step_e step;
  logic  rd_ack, wr_ack, load;
  logic [VEC_W-1:0]   c_vec;
  logic [FLAGS_W-1:0] c_flags;
  logic [WORD_W-1:0]  c_sel, c_limit, c_ip, c_sp, t_ip, t_sel;
  logic [ADDR_W-1:0]  c_base;
  logic               over_limit;
  logic [ENT_W-1:0]   ent_addr;

  assign rd_ack = rd_valid_o & rd_ready_i;
  assign wr_ack = wr_valid_o & wr_ready_i;
  assign load   = start_i & (step == ST_IDLE);

  rm_int_fsm u_fsm (
    .clk_i, .rst_ni, .start_i,
    .rd_ack_i (rd_ack),
    .wr_ack_i (wr_ack),
    .step_o   (step)
  );

  rm_int_capture #(
    .VEC_W(VEC_W), .WORD_W(WORD_W), .FLAGS_W(FLAGS_W), .BASE_W(ADDR_W)
  ) u_cap (
    .clk_i, .rst_ni,
    .load_i       (load),
    .vec_i        (vector_i),
    .flags_i      (flags_i),
    .sel_i        (cs_sel_i),
    .base_i       (cs_base_i),
    .limit_i      (cs_limit_i),
    .ip_i         (next_ip_i),
    .sp_i         (sp_i),
    .tbl_ip_we_i  (rd_ack & (step == ST_RD_IP)),
    .tbl_sel_we_i (rd_ack & (step == ST_RD_CS)),
    .rd_data_i    (rd_data_i),
    .push_i       (wr_ack),
    .vec_o        (c_vec),
    .flags_o      (c_flags),
    .sel_o        (c_sel),
    .base_o       (c_base),
    .limit_o      (c_limit),
    .ip_o         (c_ip),
    .sp_o         (c_sp),
    .tbl_ip_o     (t_ip),
    .tbl_sel_o    (t_sel)
  );

  rm_int_result #(
    .WORD_W(WORD_W), .FLAGS_W(FLAGS_W), .BASE_W(ADDR_W)
  ) u_res (
    .flags_i      (c_flags),
    .sel_i        (c_sel),
    .base_i       (c_base),
    .limit_i      (c_limit),
    .tbl_ip_i     (t_ip),
    .tbl_sel_i    (t_sel),
    .old_ip_i     (c_ip),
    .over_limit_o (over_limit),
    .ip_o         (ip_o),
    .sel_o        (cs_sel_o),
    .base_o       (cs_base_o),
    .flags_o      (flags_o)
  );

  // vector zero-extended, scaled by 4; selector word sits 2 bytes higher
  assign ent_addr   = {c_vec, (step == ST_RD_CS), 1'b0};
  assign rd_addr_o  = {{(ADDR_W-ENT_W){1'b0}}, ent_addr};
  assign rd_valid_o = (step == ST_RD_IP) | (step == ST_RD_CS);
  assign wr_valid_o = (step == ST_PUSH_FL) | (step == ST_PUSH_CS) | (step == ST_PUSH_IP);
  assign wr_addr_o  = c_sp - WSTEP;

  always_comb begin
    unique case (step)
      ST_PUSH_FL: wr_data_o = c_flags[WORD_W-1:0];
      ST_PUSH_CS: wr_data_o = c_sel;
      default:    wr_data_o = c_ip;
    endcase
  end

  assign busy_o  = step != ST_IDLE;
  assign done_o  = (step == ST_FIN) & ~over_limit;
  assign fault_o = (step == ST_FIN) &  over_limit;
  assign sp_o    = c_sp;

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o));
  // R9
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));
  // R4
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  // R3
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack && (step != ST_PUSH_IP) |=> wr_addr_o == $past(wr_addr_o) - WSTEP);
  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !done_o && !fault_o |=> busy_o);
endmodule

// File: tb/rm_int_seq_test.sv
`timescale 1ns/1ps
module rm_int_seq_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        start = 0;
  logic [7:0]  vec = 0;
  logic [31:0] flags = 0;
  logic [15:0] sel = 0, limit = 0, nip = 0, sp = 0;
  logic [19:0] base = 0;
  logic        busy, rd_valid, wr_valid, rd_ready = 0, wr_ready = 0, done, fault;
  logic [19:0] rd_addr, cs_base_o;
  logic [15:0] rd_data, wr_addr, wr_data, ip_o, cs_sel_o, sp_o;
  logic [31:0] flags_o;
  logic [15:0] mem [0:1023];

  assign rd_data = mem[rd_addr[10:1]];

  rm_int_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vector_i(vec), .flags_i(flags),
    .cs_sel_i(sel), .cs_base_i(base), .cs_limit_i(limit), .next_ip_i(nip), .sp_i(sp),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rd_data_i(rd_data), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_ready_i(wr_ready), .done_o(done), .fault_o(fault), .ip_o(ip_o), .cs_sel_o(cs_sel_o),
    .cs_base_o(cs_base_o), .flags_o(flags_o), .sp_o(sp_o)
  );

  typedef struct { bit wr; int addr; int data; } op_t;
  op_t q[$];
  int  tests = 0, fails = 0, cyc = 0, mode = 0;
  bit  running = 0, end_next = 0, exp_ok = 0;
  int  e_ip, e_sel, e_base, e_sp;
  logic [31:0] e_flags;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit rdy();
    case (mode)
      0: return 1;
      1: return cyc[0];
      default: return (cyc % 3) == 2;
    endcase
  endfunction

  // reference model, compared every clock
  always @(negedge clk) if (rst_n) begin
    cyc++;
    chk(!(rd_valid && wr_valid), "R9 rd/wr overlap", rd_valid, 0);
    if (end_next) begin
      end_next = 0;
      running = 0;
      chk(done == exp_ok, exp_ok ? "R5 done" : "R7 done", done, exp_ok);
      chk(fault == !exp_ok, "R7 fault", fault, !exp_ok);
      chk(ip_o == e_ip[15:0], exp_ok ? "R5 ip" : "R7 ip", ip_o, e_ip);
      chk(cs_sel_o == e_sel[15:0], exp_ok ? "R5 sel" : "R7 sel", cs_sel_o, e_sel);
      chk(cs_base_o == e_base[19:0], exp_ok ? "R5 base" : "R7 base", cs_base_o, e_base);
      chk(flags_o == e_flags, "R6 flags", flags_o, e_flags);
      chk(sp_o == e_sp[15:0], "R5 sp", sp_o, e_sp);
    end else begin
      chk(!done && !fault, "R9 stray end pulse", {done, fault}, 0);
    end
    if (rd_valid || wr_valid) begin
      if (q.size() == 0) chk(0, "R8 unexpected bus op", rd_valid ? rd_addr : wr_addr, 0);
      else begin
        chk(wr_valid == q[0].wr, q[0].wr ? "R3 kind" : "R2 kind", wr_valid, q[0].wr);
        if (q[0].wr) begin
          chk(wr_addr == q[0].addr[15:0], "R3 addr", wr_addr, q[0].addr);
          chk(wr_data == q[0].data[15:0], "R3 data", wr_data, q[0].data);
        end else
          chk(rd_addr == q[0].addr[19:0], "R2 addr", rd_addr, q[0].addr);
      end
    end
    rd_ready = rdy();
    wr_ready = rdy();
    if (q.size() != 0 && ((rd_valid && rd_ready) || (wr_valid && wr_ready))) begin
      void'(q.pop_front());
      if (q.size() == 0) end_next = 1;
    end
  end

  task automatic run(input int v, input int fl, input int cs, input int lim, input int ip,
                     input int s, input int tip, input int tsel, input int m, input bit dbl);
    int a;
    int w;
    a = v * 4;
    mem[a/2] = tip[15:0];
    mem[a/2+1] = tsel[15:0];
    @(negedge clk);
    mode = m;
    vec = v[7:0]; flags = fl; sel = cs[15:0]; base = 20'h1_2340 + v; limit = lim[15:0];
    nip = ip[15:0]; sp = s[15:0];
    q.push_back('{0, a, 0});
    q.push_back('{0, a + 2, 0});
    q.push_back('{1, (s - 2) & 16'hffff, fl & 16'hffff});
    q.push_back('{1, (s - 4) & 16'hffff, cs});
    q.push_back('{1, (s - 6) & 16'hffff, ip});
    exp_ok = (tip <= lim);
    e_sp = (s - 6) & 16'hffff;
    if (exp_ok) begin
      e_ip = tip; e_sel = tsel; e_base = tsel << 4;
      e_flags = fl & ~32'h0005_0300;
    end else begin
      e_ip = ip; e_sel = cs; e_base = 20'h1_2340 + v; e_flags = fl;
    end
    running = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    if (dbl) begin  // R8: new start while busy
      @(negedge clk);
      vec = 8'h55; sp = 16'h4000; start = 1;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (running && w < 200) begin @(negedge clk); w++; end
    @(negedge clk);
    chk(!busy, "R8 idle after end", busy, 0);
  endtask

  initial begin : watchdog
    #400000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 7);
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid && !wr_valid && !done && !fault, "R1 reset outputs",
        {busy, rd_valid, wr_valid, done, fault}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_valid && !wr_valid, "R1 idle after reset", busy, 0);
    run(8'h21, 32'h0000_0246, 16'h1000, 16'hffff, 16'h0123, 16'h8000, 16'h0400, 16'hc800, 0, 0);
    run(8'hff, 32'h0004_0302, 16'h2222, 16'hffff, 16'h3333, 16'h1234, 16'h0010, 16'hf000, 1, 0); // R2 max vector
    run(8'h00, 32'h0001_0100, 16'h0abc, 16'hffff, 16'h0def, 16'h0002, 16'h0020, 16'h0001, 2, 0); // R3 wrap
    run(8'h10, 32'h0000_0200, 16'h5000, 16'h8fff, 16'h0777, 16'h7000, 16'h9000, 16'h6000, 0, 0); // R7 over
    run(8'h11, 32'h0000_0200, 16'h5000, 16'h8fff, 16'h0777, 16'h7000, 16'h8fff, 16'h6000, 1, 0); // R7 equal
    run(8'h12, 32'hffff_ffff, 16'h0001, 16'hffff, 16'h0002, 16'h0100, 16'h0003, 16'h0004, 0, 0); // R6
    run(8'h80, 32'h0000_0002, 16'h3000, 16'hffff, 16'h0044, 16'h2000, 16'h0050, 16'h0600, 2, 1); // R8, R4
    run(8'h81, 32'h0004_0000, 16'h3000, 16'h0010, 16'h0044, 16'h2000, 16'h0011, 16'h0600, 2, 1); // R7 + R8
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule